// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital control side of an eight-input successive-approximation converter with a serial host port. While the active-low select `cs_n` is low, the host clocks in an 8-bit command word. The block decodes that word into a positive and a negative input select. It opens the track window and closes it into hold at fixed serial-clock edges. It then runs a 12-step binary search against an external one-bit comparator and shifts the 12-bit result back out. The analog mux, the capacitive DAC and the comparator are outside the block. They appear only as select lines, a DAC trial code and a comparator bit.

The block runs on one system clock. The serial clock reaches it as two one-cycle strobes, `sck_rise` and `sck_fall`, which a front end derives from the pin. The host sets the pace of both serial streams, and neither stream has back-pressure. The block samples `din` and `cmp_in` on every rising strobe and changes `dout` only on a falling strobe. The host must therefore keep the strobes apart by at least two system clocks.

Command word, first bit first: a start bit of 1, then channel code bits c2, c1, c0, then a mode flag (1 = single-ended, 0 = differential), then three bits that are ignored.

Top module: `adcseq_top`

## Requirements
- R1: After reset, `track`, `hold`, `conv_done` and `dout` are 0, `dac_code` is 0, `pos_sel` and `neg_sel` are 0 and `neg_com` is 1.
- R2: `track` rises one system clock after the falling strobe that follows the fifth command bit, where the start bit counts as bit one.
- R3: On the falling strobe that follows the eighth command bit, `track` falls and `hold` rises in the same cycle. `track` and `hold` are never high together.
- R4: With the mode flag at 1, `pos_sel` equals the channel code and `neg_com` is 1. The selects are updated together with the rise of `track`.
- R5: With the mode flag at 0, `pos_sel` equals the channel code, `neg_sel` equals the code with its lowest bit inverted, and `neg_com` is 0.
- R6: `dac_code` starts at 0x800 when hold begins. On each rising strobe the bit under test stays set if `cmp_in` is 1 and is cleared if it is 0, and the next lower bit is set. After twelve rising strobes `dac_code` holds the result.
- R7: `conv_done` is high for exactly one clock, one clock after the twelfth rising strobe of the search. `hold` is low on the following clock.
- R8: The result leaves on `dout` MSB first, one bit per falling strobe, starting with the falling strobe of the last search clock. After the twelve result bits `dout` stays 0 on later falling strobes.
- R9: While `cs_n` is high, every register returns to its reset value on the next clock, strobes are ignored, and `dout_en` is 0. `dout_en` is 1 whenever `cs_n` is low.
- R10: Rising strobes with `din` at 0 while the block is idle are ignored. The command word begins at the first 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts the sequence |
| sck_rise | input | 1 | One-cycle strobe for a serial-clock rising edge |
| sck_fall | input | 1 | One-cycle strobe for a serial-clock falling edge |
| din | input | 1 | Serial command data |
| cmp_in | input | 1 | Comparator: 1 when the DAC trial is below the sample |
| dout | output | 1 | Serial result data |
| dout_en | output | 1 | Output enable for the serial data pin |
| dac_code | output | 12 | Trial code driven to the capacitive DAC |
| pos_sel | output | 3 | Positive input channel select |
| neg_sel | output | 3 | Negative input channel select (differential mode) |
| neg_com | output | 1 | Negative input taken from the common pin |
| track | output | 1 | Sample switch tracking |
| hold | output | 1 | Sample switch holding; mux on the negative side |
| conv_done | output | 1 | One-cycle pulse at the end of the search |

## Verification
On every cycle, the embedded assertions check that track and hold never overlap, that track only rises on a falling strobe, and that the search pointer stays one-hot. They also check that the untested low bits of the trial code are clear, that the done pulse lasts one cycle and is followed by the release of hold, that padding bits are zero, and that a high select clears the sample strobes. Only the bench scenarios show that the decoded selects match each mode and that the shifted-out word equals the converted value. They also show that leading zeros and an abort in the middle of a search leave the next frame intact. For this the bench runs whole frames against a behavioural model.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int CH_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CTRL  = 2'd1,
    PH_CONV  = 2'd2,
    PH_SHIFT = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CH_W-1:0] pos;
    logic [CH_W-1:0] neg;
    logic            com;
  } msel_t;

  // Single-ended: positive is the code, negative is the common pin.
  // Differential: partner is the other member of the even/odd pair.
  function automatic msel_t decode_sel(input logic [CH_W-1:0] ch, input logic single);
    msel_t s;
    s.pos = ch;
    if (single) begin
      s.neg = '0;
      s.com = 1'b1;
    end else begin
      s.neg = {ch[CH_W-1:1], ~ch[0]};
      s.com = 1'b0;
    end
    return s;
  endfunction

endpackage

// File: rtl/adcseq_cmdrx.sv
module adcseq_cmdrx #(
  parameter int CW    = 8,
  parameter int CNT_W = $clog2(CW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             idle_i,
  input  logic             ctrl_i,
  input  logic             rise_i,
  input  logic             din_i,
  output logic [CW-1:0]    word_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(CW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      cnt_o  <= '0;
    end else if (abort_i) begin
      word_o <= '0;
      cnt_o  <= '0;
    end else if (rise_i) begin
      if (idle_i && din_i) begin
        word_o <= CW'(1);
        cnt_o  <= CNT_W'(1);
      end else if (ctrl_i && (cnt_o < FULL)) begin
        word_o <= {word_o[CW-2:0], din_i};
        cnt_o  <= cnt_o + CNT_W'(1);
      end
    end
  end

  a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= FULL);

  a_r10_start_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_W'(1)) |-> word_o[0]);

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_i,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic         done_o
);

  localparam logic [W-1:0] TOP_BIT = W'(1) << (W - 1);

  logic [W-1:0] ptr;
  logic [W-1:0] kept;

  assign kept = cmp_i ? code_o : (code_o & ~ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      ptr    <= '0;
      done_o <= 1'b0;
    end else if (abort_i) begin
      code_o <= '0;
      ptr    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        code_o <= TOP_BIT;
        ptr    <= TOP_BIT;
      end else if (step_i && (ptr != '0)) begin
        code_o <= kept | (ptr >> 1);
        ptr    <= ptr >> 1;
        if (ptr[0]) done_o <= 1'b1;
      end
    end
  end

  a_r6_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr));

  a_r6_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != '0) |-> ((code_o & (ptr - W'(1))) == '0));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/adcseq_txsr.sv
module adcseq_txsr #(
  parameter int W     = 12,
  parameter int LFT_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         fall_i,
  output logic         dout_o,
  output logic         empty_o
);

  logic [W-1:0]     sh;
  logic [LFT_W-1:0] left;

  assign empty_o = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      dout_o <= 1'b0;
    end else if (abort_i) begin
      sh     <= '0;
      left   <= '0;
      dout_o <= 1'b0;
    end else if (load_i) begin
      sh   <= data_i;
      left <= LFT_W'(W);
    end else if (fall_i) begin
      if (left != '0) begin
        dout_o <= sh[W-1];
        sh     <= sh << 1;
        left   <= left - LFT_W'(1);
      end else begin
        dout_o <= 1'b0;
      end
    end
  end

  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && fall_i && !load_i) |=> !dout_o);

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!dout_o && empty_o));

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int RES_W    = 12,
  parameter int CW       = 8,
  parameter int TRACK_AT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             din,
  input  logic             cmp_in,
  output logic             dout,
  output logic             dout_en,
  output logic [RES_W-1:0] dac_code,
  output logic [2:0]       pos_sel,
  output logic [2:0]       neg_sel,
  output logic             neg_com,
  output logic             track,
  output logic             hold,
  output logic             conv_done
);
  import adcseq_pkg::*;

  localparam int CNT_W = $clog2(CW + 1);
  localparam logic [CNT_W-1:0] TRK_CNT = CNT_W'(TRACK_AT);
  localparam logic [CNT_W-1:0] HLD_CNT = CNT_W'(CW);

  phase_e           phase;
  logic [CW-1:0]    word;
  logic [CNT_W-1:0] cnt;
  logic             in_idle, in_ctrl;
  logic             trk_go, hld_go, sar_step, tx_load, tx_empty;
  msel_t            dec;

  assign in_idle  = (phase == PH_IDLE);
  assign in_ctrl  = (phase == PH_CTRL);
  assign trk_go   = sck_fall && in_ctrl && (cnt == TRK_CNT);
  assign hld_go   = sck_fall && in_ctrl && (cnt == HLD_CNT);
  assign sar_step = sck_rise && (phase == PH_CONV);
  assign tx_load  = (phase == PH_CONV) && conv_done;
  assign dout_en  = !cs_n;

  // At the track point the low bits of the word hold channel code and mode flag
  assign dec = decode_sel(word[CH_W:1], word[0]);

  adcseq_cmdrx #(.CW(CW), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .abort_i(cs_n),
    .idle_i(in_idle), .ctrl_i(in_ctrl),
    .rise_i(sck_rise), .din_i(din),
    .word_o(word), .cnt_o(cnt)
  );

  adcseq_sar #(.W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .abort_i(cs_n),
    .start_i(hld_go), .step_i(sar_step), .cmp_i(cmp_in),
    .code_o(dac_code), .done_o(conv_done)
  );

  adcseq_txsr #(.W(RES_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .abort_i(cs_n),
    .load_i(tx_load), .data_i(dac_code), .fall_i(sck_fall),
    .dout_o(dout), .empty_o(tx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      track   <= 1'b0;
      hold    <= 1'b0;
      pos_sel <= '0;
      neg_sel <= '0;
      neg_com <= 1'b1;
    end else if (cs_n) begin
      phase   <= PH_IDLE;
      track   <= 1'b0;
      hold    <= 1'b0;
      pos_sel <= '0;
      neg_sel <= '0;
      neg_com <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: if (sck_rise && din) phase <= PH_CTRL;
        PH_CTRL: begin
          if (trk_go) begin
            track   <= 1'b1;
            pos_sel <= dec.pos;
            neg_sel <= dec.neg;
            neg_com <= dec.com;
          end
          if (hld_go) begin
            track <= 1'b0;
            hold  <= 1'b1;
            phase <= PH_CONV;
          end
        end
        PH_CONV: if (conv_done) begin
          hold  <= 1'b0;
          phase <= PH_SHIFT;
        end
        PH_SHIFT: if (tx_empty) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(track && hold));

  a_r2_track_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track) |-> $past(sck_fall));

  a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !hold);

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!track && !hold && !conv_done));

  a_r5_pair_partner: assert property (@(posedge clk) disable iff (!rst_n)
    (!neg_com) |-> (neg_sel[2:1] == pos_sel[2:1] && neg_sel[0] != pos_sel[0]));

endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck_rise = 1'b0, sck_fall = 1'b0, din = 1'b0;
  logic cmp_in;
  logic dout, dout_en, neg_com, track, hold, conv_done;
  logic [11:0] dac_code;
  logic [2:0]  pos_sel, neg_sel;
  logic [11:0] vin_cur = 12'd0;

  int n_chk = 0, n_bad = 0;
  bit comparing = 0;
  bit finished = 0;
  logic last_q;

  always #4 clk = ~clk;

  assign cmp_in = (dac_code <= vin_cur);

  adcseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .din(din), .cmp_in(cmp_in), .dout(dout), .dout_en(dout_en), .dac_code(dac_code),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .neg_com(neg_com), .track(track),
    .hold(hold), .conv_done(conv_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number, bit count, trial index
  int m_ph, m_n, m_word, m_k, m_acc, m_left, m_sh;
  int m_track, m_hold, m_done, m_dout, m_pos, m_neg, m_com;

  task automatic m_clear();
    m_ph = 0; m_n = 0; m_word = 0; m_k = -1; m_acc = 0; m_left = 0; m_sh = 0;
    m_track = 0; m_hold = 0; m_done = 0; m_dout = 0; m_pos = 0; m_neg = 0; m_com = 1;
  endtask

  initial m_clear();

  always @(posedge clk) begin
    if (!rst_n || cs_n) m_clear();
    else begin
      int d, lempty, ch;
      bit ld;
      d = m_done; m_done = 0;
      lempty = (m_left == 0);
      ld = (m_ph == 2) && (d != 0);
      if (ld) begin m_sh = m_acc; m_left = 12; end
      else if (sck_fall) begin
        if (m_left > 0) begin
          m_dout = (m_sh >> 11) & 1; m_sh = (m_sh << 1) & 12'hFFF; m_left--;
        end else m_dout = 0;
      end
      case (m_ph)
        0: if (sck_rise && din) begin m_word = 1; m_n = 1; m_ph = 1; end
        1: begin
          if (sck_rise && m_n < 8) begin m_word = (m_word << 1) | int'(din); m_n++; end
          if (sck_fall && m_n == 5) begin
            ch = (m_word >> 1) & 7;
            m_pos = ch;
            if (m_word & 1) begin m_neg = 0; m_com = 1; end
            else begin m_neg = ch ^ 1; m_com = 0; end
            m_track = 1;
          end
          if (sck_fall && m_n == 8) begin
            m_track = 0; m_hold = 1; m_ph = 2; m_k = 11; m_acc = 0;
          end
        end
        2: if (d != 0) begin m_hold = 0; m_ph = 3; end
           else if (sck_rise && m_k >= 0) begin
             if (cmp_in) m_acc |= (1 << m_k);
             if (m_k == 0) m_done = 1;
             m_k--;
           end
        default: if (lempty) m_ph = 0;
      endcase
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (comparing) begin
      chk("R2 track", int'(track), m_track);
      chk("R3 hold", int'(hold), m_hold);
      chk("R4 pos_sel", int'(pos_sel), m_pos);
      chk("R5 neg_sel", int'(neg_sel), m_neg);
      chk("R5 neg_com", int'(neg_com), m_com);
      chk("R6 dac_code", int'(dac_code), (m_k >= 0) ? (m_acc | (1 << m_k)) : m_acc);
      chk("R7 conv_done", int'(conv_done), m_done);
      chk("R8 dout", int'(dout), m_dout);
      chk("R9 dout_en", int'(dout_en), int'(!cs_n));
    end
  end

  task automatic sbit(input logic b);
    @(negedge clk); din = b; sck_rise = 1'b1;
    @(negedge clk); sck_rise = 1'b0;
    @(negedge clk);
    @(negedge clk); sck_fall = 1'b1;
    @(negedge clk); sck_fall = 1'b0; last_q = dout;
    @(negedge clk);
  endtask

  // lead: zeros sent before the start bit; abort_at: search clocks before cs_n rises (-1: none)
  task automatic frame(input logic [2:0] ch, input logic sgl, input logic [11:0] v,
                       input int lead, input int abort_at);
    logic [7:0] w;
    logic [11:0] got;
    w = {1'b1, ch, sgl, 3'b101};
    vin_cur = v;
    got = '0;
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < lead; i++) begin
      sbit(1'b0);
      chk("R10 idle after zero", int'(track), 0);
    end
    for (int i = 7; i >= 0; i--) begin
      sbit(w[i]);
      if (i == 3) chk("R2 track after bit five", int'(track), 1);
    end
    chk("R3 hold after bit eight", int'(hold), 1);
    chk("R3 track low in hold", int'(track), 0);
    chk("R4 positive select", int'(pos_sel), int'(ch));
    if (sgl) chk("R4 common negative", int'(neg_com), 1);
    else chk("R5 pair partner", int'(neg_sel), int'(ch ^ 3'd1));
    if (abort_at >= 0) begin
      for (int i = 0; i < abort_at; i++) sbit(1'b0);
      @(negedge clk); cs_n = 1'b1;
      sbit(1'b1);
      chk("R9 abort hold", int'(hold), 0);
      chk("R9 abort dac", int'(dac_code), 0);
      chk("R9 abort dout_en", int'(dout_en), 0);
    end else begin
      for (int i = 0; i < 11; i++) sbit(1'b0);
      for (int i = 11; i >= 0; i--) begin
        sbit(1'b0);
        got[i] = last_q;
      end
      chk("R8 shifted result", int'(got), int'(v));
      chk("R6 final dac code", int'(dac_code), int'(v));
      for (int i = 0; i < 2; i++) begin
        sbit(1'b0);
        chk("R8 padding zero", int'(last_q), 0);
      end
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values at the ports
    chk("R1 track", int'(track), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 done", int'(conv_done), 0);
    chk("R1 dout", int'(dout), 0);
    chk("R1 dac", int'(dac_code), 0);
    chk("R1 neg_com", int'(neg_com), 1);
    chk("R1 pos_sel", int'(pos_sel), 0);
    comparing = 1;
    // R9: strobes with cs_n high are ignored
    sbit(1'b1); sbit(1'b1);
    chk("R9 ignored while deselected", int'(track), 0);
    frame(3'd5, 1'b1, 12'hA5C, 0, -1);
    frame(3'd2, 1'b0, 12'hFFF, 0, -1);
    frame(3'd3, 1'b0, 12'h000, 0, -1);
    frame(3'd6, 1'b1, 12'h801, 3, -1);
    frame(3'd1, 1'b0, 12'h3C7, 0, 5);
    frame(3'd7, 1'b1, 12'h7FE, 1, -1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule